// File: doc/BRIEF.md
# Tamper-Resistant Watchdog Timer

This block guards a system against software that has stopped making progress. It counts prescaled ticks of the main system clock and starts on its own once power-on reset is released. It needs no configuration from software. If the count reaches the selected interval, the block fires one of two actions: a stretched system reset pulse or a one-cycle non-maskable interrupt. A strap input chooses which one.

Software keeps the timer from firing only by writing an exact two-step unlock sequence over a simple write/read register bus. The two writes go to two fully decoded addresses, each with its own key value. The second write must follow the first within a short window, with no other write between them. No register path can stop or disable the counter.

An external debug jumper suppresses the timeout action while a debugger holds the processor. A sticky status bit records that a timeout fired. Only power-on reset or a software read of that bit clears it, so the bit is still set after the reset that the watchdog itself drove.

Top module: `wdt_guard`

## Requirements
- R1: After `por_n` rises, with no bus writes, the selected action first fires at the clock edge numbered PRESC_DIV × interval ticks, counting edges from the release.
- R2: The interval in ticks is BASE_TICKS shifted left by twice `interval_sel` (×1, ×4, ×16, ×64). `interval_sel` and `action_strap` are captured on the first edge after release. Later changes to either input have no effect.
- R3: A retrigger is a write of 0x5A to address 0x10, then a write of 0xC3 to address 0x14 arriving 1 to UNLOCK_WIN cycles later. The retrigger restarts the prescaler and the counter, so the next expiry comes one full interval after the edge that took the second write.
- R4: Any of the following cancels an attempt without reloading the counter: the second write arriving more than UNLOCK_WIN cycles after the first, any other write between the two, a wrong key value in either write, or the two writes in reverse order.
- R5: Writes to any other address, or with any other data, neither stop, delay nor disable the counter.
- R6: While `debug_jumper` is 1 at an expiry, no reset, no NMI and no status update happen. The count restarts for a new interval.
- R7: With `action_strap` = 0, an expiry drives `sys_rst_out` high for exactly RST_LEN cycles.
- R8: With `action_strap` = 1, an expiry drives `nmi_out` high for exactly one cycle and leaves `sys_rst_out` low.
- R9: An expiry sets the status bit. A read (`bus_rd`) of address 0x18 returns the bit in `bus_rdata[0]` on the next cycle and then clears it. The bit stays set through the watchdog's own reset pulse.
- R10: During and right after power-on reset, `sys_rst_out`, `nmi_out` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| interval_sel | input | 2 | Interval select strap, captured after power-on reset |
| action_strap | input | 1 | 0 selects system reset, 1 selects NMI, captured after power-on reset |
| debug_jumper | input | 1 | 1 suppresses the timeout action |
| sys_rst_out | output | 1 | Stretched system reset pulse |
| nmi_out | output | 1 | One-cycle non-maskable interrupt pulse |

## Verification
The bench builds the block with PRESC_DIV = 4, BASE_TICKS = 4, UNLOCK_WIN = 4 and RST_LEN = 8. With these values the four intervals are 16, 64, 256 and 1024 cycles, so every select value can expire within the run. Expiry edges are predicted to the exact cycle. Gaps just inside and just outside the unlock window, back-to-back retriggers, jumper release between two expiries, and the status bit across a full reset pulse all fit in a few hundred cycles. Random idle gaps and random stray writes are mixed with directed rejection cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic {
      ACT_RESET = 1'b0,
      ACT_NMI   = 1'b1
   } wdt_action_e;

   typedef enum logic {
      UL_IDLE  = 1'b0,
      UL_ARMED = 1'b1
   } wdt_unlock_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("wdt_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = !restart;
   end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     pre_q <= '0;
         else if (restart)               pre_q <= '0;
         else if (pre_q == W'(DIV - 1))  pre_q <= '0;
         else                            pre_q <= pre_q + W'(1);
      end

      assign tick = (pre_q == W'(DIV - 1)) && !restart;

      AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         pre_q <= W'(DIV - 1)) else $error("prescaler out of range"); // R1
      AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
         restart |=> (pre_q == '0)) else $error("prescaler not restarted"); // R3
   end

endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
   import wdt_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter int                WIN        = 4,
   parameter logic [ADDR_W-1:0] KEY_A_ADDR = 'h10,
   parameter logic [DATA_W-1:0] KEY_A_DATA = 'h5A,
   parameter logic [ADDR_W-1:0] KEY_B_ADDR = 'h14,
   parameter logic [DATA_W-1:0] KEY_B_DATA = 'hC3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              accept
);

   localparam int WW = $clog2(WIN + 1);

   if (WIN < 1) begin : g_bad_win
      $error("wdt_unlock: WIN must be at least 1");
   end
   if (KEY_A_ADDR == KEY_B_ADDR) begin : g_bad_keys
      $error("wdt_unlock: the two key addresses must differ");
   end

   wdt_unlock_e   state_q;
   logic [WW-1:0] win_q;
   logic          hit_a;
   logic          hit_b;

   assign hit_a  = wr_en && (addr == KEY_A_ADDR) && (wdata == KEY_A_DATA);
   assign hit_b  = wr_en && (addr == KEY_B_ADDR) && (wdata == KEY_B_DATA);
   assign accept = (state_q == UL_ARMED) && hit_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= UL_IDLE;
         win_q   <= '0;
      end else if (state_q == UL_ARMED) begin
         // Any write ends the attempt: the right one is accepted, all others cancel.
         if (wr_en || (win_q == WW'(1))) state_q <= UL_IDLE;
         win_q <= win_q - WW'(1);
      end else if (hit_a) begin
         state_q <= UL_ARMED;
         win_q   <= WW'(WIN);
      end
   end

   AST_ACCEPT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (state_q == UL_IDLE)) else $error("still armed after accept"); // R3
   AST_NO_DOUBLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept) else $error("two accepts in a row"); // R4
   AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == UL_ARMED) |-> (win_q != '0)) else $error("armed with empty window"); // R4

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int BASE  = 16,
   parameter int LIM_W = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       expire
);

   if (BASE < 1) begin : g_bad_base
      $error("wdt_counter: BASE must be at least 1");
   end

   logic [LIM_W-1:0] cnt_q;
   logic [LIM_W-1:0] limit;

   assign limit  = LIM_W'(BASE) << (2 * sel);
   assign expire = tick && !restart && (cnt_q == limit - LIM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (restart)  cnt_q <= '0;
      else if (expire)   cnt_q <= '0;
      else if (tick)     cnt_q <= cnt_q + LIM_W'(1);
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit) else $error("count beyond interval"); // R2
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0)) else $error("count not reloaded"); // R3

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter int                PRESC_DIV   = 50000,
   parameter int                BASE_TICKS  = 16,
   parameter int                UNLOCK_WIN  = 4,
   parameter int                RST_LEN     = 16,
   parameter logic [ADDR_W-1:0] KEY_A_ADDR  = 'h10,
   parameter logic [DATA_W-1:0] KEY_A_DATA  = 'h5A,
   parameter logic [ADDR_W-1:0] KEY_B_ADDR  = 'h14,
   parameter logic [DATA_W-1:0] KEY_B_DATA  = 'hC3,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h18
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [1:0]        interval_sel,
   input  logic              action_strap,
   input  logic              debug_jumper,
   output logic              sys_rst_out,
   output logic              nmi_out
);

   localparam int LIM_W = $clog2(BASE_TICKS * 64 + 1);

   if (PRESC_DIV * BASE_TICKS < 2 || RST_LEN < 1) begin : g_bad_cfg
      $error("wdt_guard: interval or reset length too small");
   end
   if (STATUS_ADDR == KEY_A_ADDR || STATUS_ADDR == KEY_B_ADDR) begin : g_bad_map
      $error("wdt_guard: status address collides with a key address");
   end

   // Straps captured once after power-on reset.
   logic        cfg_valid;
   logic [1:0]  sel_q;
   wdt_action_e act_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg_valid <= 1'b0;
         sel_q     <= 2'd0;
         act_q     <= ACT_RESET;
      end else if (!cfg_valid) begin
         cfg_valid <= 1'b1;
         sel_q     <= interval_sel;
         act_q     <= wdt_action_e'(action_strap);
      end
   end

   logic retrig;
   logic tick;
   logic expire_evt;
   logic fire;

   wdt_unlock #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN(UNLOCK_WIN),
      .KEY_A_ADDR(KEY_A_ADDR), .KEY_A_DATA(KEY_A_DATA),
      .KEY_B_ADDR(KEY_B_ADDR), .KEY_B_DATA(KEY_B_DATA)
   ) u_unlock (
      .clk(clk), .rst_n(por_n), .wr_en(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .accept(retrig)
   );

   wdt_prescaler #(.DIV(PRESC_DIV)) u_pre (
      .clk(clk), .rst_n(por_n), .restart(retrig), .tick(tick)
   );

   wdt_counter #(.BASE(BASE_TICKS), .LIM_W(LIM_W)) u_cnt (
      .clk(clk), .rst_n(por_n), .tick(tick), .restart(retrig),
      .sel(sel_q), .expire(expire_evt)
   );

   assign fire = expire_evt && !debug_jumper;

   // Reset pulse stretcher; the variant depends on the required length.
   if (RST_LEN == 1) begin : g_rst_short
      logic rst_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) rst_q <= 1'b0;
         else        rst_q <= fire && (act_q == ACT_RESET);
      end
      assign sys_rst_out = rst_q;
   end else begin : g_rst_long
      localparam int RW = $clog2(RST_LEN + 1);
      logic [RW-1:0] rst_cnt_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                               rst_cnt_q <= '0;
         else if (fire && (act_q == ACT_RESET))    rst_cnt_q <= RW'(RST_LEN);
         else if (rst_cnt_q != '0)                 rst_cnt_q <= rst_cnt_q - RW'(1);
      end
      assign sys_rst_out = (rst_cnt_q != '0);

      AST_RST_STRETCH: assert property (@(posedge clk) disable iff (!por_n)
         $rose(sys_rst_out) |=> sys_rst_out) else $error("reset pulse too short"); // R7
   end

   logic nmi_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) nmi_q <= 1'b0;
      else        nmi_q <= fire && (act_q == ACT_NMI);
   end
   assign nmi_out = nmi_q;

   // Sticky timeout status; its reset is power-on only.
   logic status_q;
   logic rd_hit;
   logic [DATA_W-1:0] rdata_q;

   assign rd_hit = bus_rd && (bus_addr == STATUS_ADDR);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      status_q <= 1'b0;
      else if (fire)   status_q <= 1'b1;
      else if (rd_hit) status_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      rdata_q <= '0;
      else if (rd_hit) rdata_q <= DATA_W'(status_q);
      else             rdata_q <= '0;
   end
   assign bus_rdata = rdata_q;

   AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
      nmi_out |=> !nmi_out) else $error("nmi wider than one cycle"); // R8
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!por_n)
      !(nmi_out && sys_rst_out)) else $error("both actions active"); // R8
   AST_JUMPER_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
      (expire_evt && debug_jumper) |=> (!nmi_out && !$rose(sys_rst_out)))
      else $error("action despite jumper"); // R6
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      (status_q && !rd_hit) |=> status_q) else $error("status lost"); // R9
   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!por_n)
      (cfg_valid && $past(cfg_valid)) |-> ($stable(sel_q) && $stable(act_q)))
      else $error("straps changed after capture"); // R2

endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;

   localparam int DIV  = 4;
   localparam int BASE = 4;
   localparam int WIN  = 4;
   localparam int RLEN = 8;
   localparam logic [7:0] A_ADR = 8'h10, A_KEY = 8'h5A;
   localparam logic [7:0] B_ADR = 8'h14, B_KEY = 8'hC3;
   localparam logic [7:0] S_ADR = 8'h18;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] interval_sel = 2'd0;
   logic       action_strap = 1'b0, debug_jumper = 1'b0;
   logic       sys_rst_out, nmi_out;

   wdt_guard #(
      .PRESC_DIV(DIV), .BASE_TICKS(BASE), .UNLOCK_WIN(WIN), .RST_LEN(RLEN)
   ) u_dut (
      .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .interval_sel(interval_sel), .action_strap(action_strap),
      .debug_jumper(debug_jumper), .sys_rst_out(sys_rst_out), .nmi_out(nmi_out)
   );

   always #5 clk = ~clk;

   int checks = 0, errors = 0, total = 0;
   int cyc = 0;
   int rst_seen, rst_rise, rst_hi, nmi_seen, nmi_rise, nmi_hi;
   logic rst_prev, nmi_prev;

   always @(posedge clk) begin
      cyc <= por_n ? cyc + 1 : 0;
      total <= total + 1;
      if (total == 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", total);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (por_n) begin
         if (sys_rst_out && !rst_prev && rst_seen == 0) begin rst_seen = 1; rst_rise = cyc; end
         if (nmi_out && !nmi_prev && nmi_seen == 0) begin nmi_seen = 1; nmi_rise = cyc; end
         if (sys_rst_out) rst_hi++;
         if (nmi_out) nmi_hi++;
      end
      rst_prev = sys_rst_out;
      nmi_prev = nmi_out;
   end

   function automatic int interval(input int sel);
      return DIV * (BASE << (2 * sel));
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic power_on(input int sel, input logic strap, input logic jmp);
      @(negedge clk);
      por_n = 1'b0; bus_wr = 0; bus_rd = 0;
      interval_sel = 2'(sel); action_strap = strap; debug_jumper = jmp;
      repeat (3) @(negedge clk);
      chk("R10 reset rst", int'(sys_rst_out), 0);
      chk("R10 reset nmi", int'(nmi_out), 0);
      chk("R10 reset rdata", int'(bus_rdata), 0);
      rst_seen = 0; rst_rise = 0; rst_hi = 0; nmi_seen = 0; nmi_rise = 0; nmi_hi = 0;
      por_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd_status(output int v);
      bus_rd = 1; bus_addr = S_ADR;
      @(negedge clk);
      bus_rd = 0;
      v = int'(bus_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic unlock(input int gap, output int acc);
      wr(A_ADR, A_KEY);
      idle(gap - 1);
      wr(B_ADR, B_KEY);
      acc = cyc;
   endtask

   int v, e;

   initial begin
      void'($urandom(32'd20240611));

      // R1, R7, R9: free-running expiry with reset action
      power_on(0, 1'b0, 1'b0);
      idle(1);
      chk("R10 rdata after release", int'(bus_rdata), 0);
      wait_until(interval(0) + RLEN + 4);
      chk("R1 first expiry cycle", rst_rise, interval(0));
      chk("R7 reset pulse length", rst_hi, RLEN);
      chk("R8 no nmi in reset mode", nmi_seen, 0);
      rd_status(v); chk("R9 status survives own reset", v, 1);
      rd_status(v); chk("R9 status cleared by read", v, 0);

      // R2: select captured once, later changes ignored
      power_on(1, 1'b0, 1'b0);
      idle(5);
      interval_sel = 2'd3;
      wait_until(interval(1) + 2);
      chk("R2 sel=1 interval, later change ignored", rst_rise, interval(1));
      power_on(2, 1'b0, 1'b0);
      idle(3); interval_sel = 2'd0;
      wait_until(interval(2) + 2);
      chk("R2 sel=2 interval", rst_rise, interval(2));
      power_on(3, 1'b0, 1'b0);
      wait_until(interval(3) + 2);
      chk("R2 sel=3 interval", rst_rise, interval(3));

      // R3: directed retrigger at the window edge
      power_on(1, 1'b0, 1'b0);
      wait_until(40);
      unlock(WIN, e);
      wait_until(e + interval(1) + 2);
      chk("R3 retrigger with gap WIN", rst_rise, e + interval(1));

      // R4: rejected attempts leave the original expiry in place
      power_on(1, 1'b0, 1'b0);
      wait_until(10); wr(B_ADR, B_KEY); wr(A_ADR, A_KEY);
      wait_until(interval(1) + 2);
      chk("R4 reversed order rejected", rst_rise, interval(1));

      power_on(1, 1'b0, 1'b0);
      wait_until(10); wr(A_ADR, A_KEY); wr(8'h20, 8'h00); wr(B_ADR, B_KEY);
      wait_until(interval(1) + 2);
      chk("R4 intervening write rejected", rst_rise, interval(1));

      power_on(1, 1'b0, 1'b0);
      wait_until(10); wr(A_ADR, A_KEY); idle(WIN); wr(B_ADR, B_KEY);
      wait_until(interval(1) + 2);
      chk("R4 late second write rejected", rst_rise, interval(1));

      power_on(1, 1'b0, 1'b0);
      wait_until(10); wr(A_ADR, 8'h5B); wr(B_ADR, B_KEY);
      wait_until(interval(1) + 2);
      chk("R4 wrong first key rejected", rst_rise, interval(1));

      power_on(1, 1'b0, 1'b0);
      wait_until(10); wr(A_ADR, A_KEY); wr(B_ADR, 8'h3C);
      wait_until(interval(1) + 2);
      chk("R4 wrong second key rejected", rst_rise, interval(1));

      // R5: random stray writes do not disturb the count
      power_on(1, 1'b0, 1'b0);
      for (int i = 0; i < 10; i++) begin
         logic [7:0] a;
         a = 8'($urandom);
         while (a == A_ADR) a = 8'($urandom);
         wr(a, 8'($urandom));
         idle(int'($urandom % 4));
      end
      wait_until(interval(1) + 2);
      chk("R5 stray writes ignored", rst_rise, interval(1));

      // R3: random back-to-back retriggers keep it alive
      power_on(0, 1'b0, 1'b0);
      e = 0;
      for (int i = 0; i < 20; i++) begin
         idle(int'($urandom % 9));
         unlock(1 + int'($urandom % WIN), e);
      end
      chk("R3 no expiry under retriggers", rst_seen, 0);
      rd_status(v); chk("R9 status clear without expiry", v, 0);
      wait_until(e + interval(0) + 2);
      chk("R3 expiry after last retrigger", rst_rise, e + interval(0));

      // R6: jumper blocks action and status, counting continues
      power_on(0, 1'b0, 1'b1);
      wait_until(40);
      chk("R6 no reset under jumper", rst_seen, 0);
      rd_status(v); chk("R6 no status under jumper", v, 0);
      debug_jumper = 1'b0;
      wait_until(3 * interval(0) + 2);
      chk("R6 expiry resumes after jumper", rst_rise, 3 * interval(0));

      // R8: NMI action
      power_on(0, 1'b1, 1'b0);
      wait_until(interval(0) + 10);
      chk("R8 nmi cycle", nmi_rise, interval(0));
      chk("R8 nmi one cycle", nmi_hi, 1);
      chk("R8 no reset in nmi mode", rst_seen, 0);
      rd_status(v); chk("R9 status after nmi", v, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule